// File: doc/BRIEF.md
# DRAM Bank Row/Column Address Mapper

This block turns a CPU physical address into the coordinates a DRAM sequencer needs for a memory array split into four banks. Every bank owns a fixed 16 MB slot of the address space, whatever capacity is actually fitted in it. Each bank's fitted capacity is described by a 2-bit size code held in one configuration byte. The code selects one of four row by column geometries. The mapper produces the bank number, a hit flag, and row and column addresses cut down to that geometry.

A bank smaller than its 16 MB slot repeats its contents across the slot. The mapper reports this with an alias flag whenever the address points past the fitted capacity. The row and column it returns in that case are the wrapped ones that the DRAM actually sees. All outputs are registered, one clock after the inputs are presented. Strobe timing, refresh and data movement belong to neighbouring blocks.

Top module: `dram_addr_mapper`

## Requirements
- R1: `map_bank` equals address bits [25:24] of the address presented one cycle earlier. Bank n occupies the 16 MB slot starting at n x 16 MB.
- R2: The size code of bank n is taken from `bank_cfg[2n+1:2n]`. Bank 0 uses bits [1:0] and bank 3 uses bits [7:6].
- R3: Size code 0 (1 MB) gives 9 row bits and 9 column bits.
- R4: Size code 1 (4 MB) gives 10 row bits and 10 column bits.
- R5: Size code 2 (16 MB) gives 11 row bits and 11 column bits.
- R6: Size code 3 (8 MB) gives 11 row bits and 10 column bits.
- R7: The column is address bits from bit 2 upward, masked to the column width. The row is address bits from bit 13 upward, masked to the row width.
- R8: `map_row` and `map_col` are 11 bits wide. Bits above the selected width are zero.
- R9: `map_alias` is 1 when any address bit in [23:0] at or above the bank capacity is set. For code 0 that is bits [23:20], for code 1 bits [23:22], and for code 3 bit 23. Code 2 never aliases.
- R10: `map_hit` is 1 one cycle after `req_valid` was 1 with an address below 64 MB (bits [31:26] all zero). Bank, row, column and alias follow the address whether or not `req_valid` is high.
- R11: While `rst_n` is low, all outputs are zero. The reset is asynchronous and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Address strobe |
| req_addr | input | 32 | CPU physical byte address |
| bank_cfg | input | 8 | Four 2-bit bank size codes |
| map_bank | output | 2 | Registered bank number |
| map_hit | output | 1 | Registered hit: strobe high and address below 64 MB |
| map_row | output | 11 | Registered row address, zero-extended |
| map_col | output | 11 | Registered column address, zero-extended |
| map_alias | output | 1 | Registered flag: address above the bank's fitted capacity |

## Verification
The hardest case to reach is an aliased access. It needs an address that lands in a chosen bank, sets a bit just above that bank's capacity, and meets a size code that makes that bit count. The vector table therefore pairs configuration bytes that give each bank a different code with addresses placed on either side of each capacity boundary. One configuration is then reversed so that every code is also seen in a different bank slot. Directed steps cover the 64 MB hit edge, a dropped strobe, and a reset asserted in the middle of traffic.

// File: rtl/dram_map_pkg.sv
package dram_map_pkg;

  localparam int RC_W  = 11;  // row/column output width
  localparam int WIN_W = 24;  // bits inside one bank slot

  typedef enum logic [1:0] {
    SZ_1M  = 2'd0,
    SZ_4M  = 2'd1,
    SZ_16M = 2'd2,
    SZ_8M  = 2'd3
  } size_code_e;

  typedef struct packed {
    logic [3:0] row_bits;
    logic [3:0] col_bits;
    logic [4:0] cap_log2;
  } geom_t;

  // size code -> geometry (order of codes is not monotonic in capacity)
  function automatic geom_t decode_geom(input size_code_e code);
    geom_t g;
    case (code)
      SZ_1M:   g = '{row_bits: 4'd9,  col_bits: 4'd9,  cap_log2: 5'd20};
      SZ_4M:   g = '{row_bits: 4'd10, col_bits: 4'd10, cap_log2: 5'd22};
      SZ_8M:   g = '{row_bits: 4'd11, col_bits: 4'd10, cap_log2: 5'd23};
      default: g = '{row_bits: 4'd11, col_bits: 4'd11, cap_log2: 5'd24};
    endcase
    return g;
  endfunction

  // low-order mask of the given number of bits
  function automatic logic [RC_W-1:0] width_mask(input logic [3:0] nbits);
    logic [RC_W-1:0] m;
    for (int i = 0; i < RC_W; i++) m[i] = (i < int'(nbits));
    return m;
  endfunction

  // any slot-offset bit at or above the capacity set?
  function automatic logic beyond_cap(input logic [WIN_W-1:0] off,
                                      input logic [4:0]       cap);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < WIN_W; i++)
      if (i >= int'(cap) && off[i]) hit = 1'b1;
    return hit;
  endfunction

endpackage

// File: rtl/dram_cfg_select.sv
module dram_cfg_select #(
  parameter int NUM_BANKS = 4,
  parameter int CODE_W    = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CFG_W    = NUM_BANKS * CODE_W
) (
  input  logic [CFG_W-1:0]  cfg_bus,
  input  logic [BANK_W-1:0] bank_sel,
  output logic [CODE_W-1:0] code_out
);

  logic [CODE_W-1:0] code_arr [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_field
    assign code_arr[g] = cfg_bus[g*CODE_W +: CODE_W];
  end

  assign code_out = code_arr[bank_sel];

endmodule

// File: rtl/dram_geom_decode.sv
module dram_geom_decode
  import dram_map_pkg::*;
(
  input  size_code_e       code_in,
  output logic [RC_W-1:0]  row_mask,
  output logic [RC_W-1:0]  col_mask,
  output logic [4:0]       cap_log2
);

  geom_t geom;

  always_comb begin
    geom     = decode_geom(code_in);
    row_mask = width_mask(geom.row_bits);
    col_mask = width_mask(geom.col_bits);
    cap_log2 = geom.cap_log2;
  end

endmodule

// File: rtl/dram_addr_slice.sv
module dram_addr_slice
  import dram_map_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ROW_LSB = 13,
  parameter int COL_LSB = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [RC_W-1:0]   row_mask,
  input  logic [RC_W-1:0]   col_mask,
  input  logic [4:0]        cap_log2,
  output logic [RC_W-1:0]   row_out,
  output logic [RC_W-1:0]   col_out,
  output logic              alias_out
);

  logic [ADDR_W-1:0] row_sh;
  logic [ADDR_W-1:0] col_sh;

  always_comb begin
    row_sh    = addr >> ROW_LSB;
    col_sh    = addr >> COL_LSB;
    row_out   = row_sh[RC_W-1:0] & row_mask;
    col_out   = col_sh[RC_W-1:0] & col_mask;
    alias_out = beyond_cap(addr[WIN_W-1:0], cap_log2);
  end

endmodule

// File: rtl/dram_addr_mapper.sv
module dram_addr_mapper
  import dram_map_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_BANKS = 4,
  parameter int CODE_W    = 2,
  parameter int ROW_LSB   = 13,
  parameter int COL_LSB   = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int BANK_LSB = WIN_W,
  localparam int TOP_LSB  = BANK_LSB + BANK_W,
  localparam int CFG_W    = NUM_BANKS * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CFG_W-1:0]  bank_cfg,
  output logic [BANK_W-1:0] map_bank,
  output logic              map_hit,
  output logic [RC_W-1:0]   map_row,
  output logic [RC_W-1:0]   map_col,
  output logic              map_alias
);

  // ---- named internal events ----
  logic [BANK_W-1:0] cur_bank;
  logic              in_range;
  logic              cur_hit;
  logic [CODE_W-1:0] cur_code_raw;
  size_code_e        cur_code;
  logic [RC_W-1:0]   cur_row_mask;
  logic [RC_W-1:0]   cur_col_mask;
  logic [4:0]        cur_cap;
  logic [RC_W-1:0]   cur_row;
  logic [RC_W-1:0]   cur_col;
  logic              cur_alias;
  size_code_e        q_code;

  assign cur_bank = req_addr[BANK_LSB +: BANK_W];
  assign in_range = (req_addr[ADDR_W-1:TOP_LSB] == '0);
  assign cur_hit  = req_valid & in_range;

  dram_cfg_select #(.NUM_BANKS(NUM_BANKS), .CODE_W(CODE_W)) cfg_sel_i (
    .cfg_bus  (bank_cfg),
    .bank_sel (cur_bank),
    .code_out (cur_code_raw)
  );

  assign cur_code = size_code_e'(cur_code_raw);

  dram_geom_decode geom_i (
    .code_in  (cur_code),
    .row_mask (cur_row_mask),
    .col_mask (cur_col_mask),
    .cap_log2 (cur_cap)
  );

  dram_addr_slice #(.ADDR_W(ADDR_W), .ROW_LSB(ROW_LSB), .COL_LSB(COL_LSB)) slice_i (
    .addr      (req_addr),
    .row_mask  (cur_row_mask),
    .col_mask  (cur_col_mask),
    .cap_log2  (cur_cap),
    .row_out   (cur_row),
    .col_out   (cur_col),
    .alias_out (cur_alias)
  );

  // ---- output stage (R11 async reset) ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_bank  <= '0;
      map_hit   <= 1'b0;
      map_row   <= '0;
      map_col   <= '0;
      map_alias <= 1'b0;
      q_code    <= SZ_1M;
    end else begin
      map_bank  <= cur_bank;
      map_hit   <= cur_hit;
      map_row   <= cur_row;
      map_col   <= cur_col;
      map_alias <= cur_alias;
      q_code    <= cur_code;
    end
  end

  // ---- assertions ----
  p_bank_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> map_bank == $past(req_addr[BANK_LSB +: BANK_W]));

  p_hit_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> map_hit == ($past(req_valid) && $past(req_addr[ADDR_W-1:TOP_LSB]) == '0));

  p_small_geom_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_code == SZ_1M |-> (map_row[RC_W-1:9] == '0 && map_col[RC_W-1:9] == '0));

  p_mid_geom_r4: assert property (@(posedge clk) disable iff (!rst_n)
    q_code == SZ_4M |-> (map_row[RC_W-1] == 1'b0 && map_col[RC_W-1] == 1'b0));

  p_col_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q_code == SZ_8M |-> map_col[RC_W-1] == 1'b0);

  p_full_no_alias_r9: assert property (@(posedge clk) disable iff (!rst_n)
    q_code == SZ_16M |-> !map_alias);

  p_reset_clear_r11: assert property (@(posedge clk)
    !rst_n |-> (!map_hit && !map_alias && map_row == '0 && map_col == '0));

endmodule

// File: tb/dram_addr_mapper_tb.sv
`timescale 1ns/1ps
module dram_addr_mapper_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0]  bank_cfg = '0;
  logic [1:0]  map_bank;
  logic        map_hit;
  logic [10:0] map_row;
  logic [10:0] map_col;
  logic        map_alias;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dram_addr_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .bank_cfg(bank_cfg), .map_bank(map_bank), .map_hit(map_hit),
    .map_row(map_row), .map_col(map_col), .map_alias(map_alias)
  );

  typedef struct packed {
    logic        v;
    logic [31:0] a;
    logic [7:0]  c;
    logic        hit;
    logic        al;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_1234, 8'hE4, 1'b1, 1'b0},
    '{1'b1, 32'h0010_0000, 8'hE4, 1'b1, 1'b1},
    '{1'b1, 32'h0140_0000, 8'hE4, 1'b1, 1'b1},
    '{1'b1, 32'h013F_FFFC, 8'hE4, 1'b1, 1'b0},
    '{1'b1, 32'h02FF_FFFC, 8'hE4, 1'b1, 1'b0},
    '{1'b1, 32'h0380_0000, 8'hE4, 1'b1, 1'b1},
    '{1'b1, 32'h037F_FFFC, 8'hE4, 1'b1, 1'b0},
    '{1'b1, 32'h0400_0000, 8'hE4, 1'b0, 1'b0},
    '{1'b0, 32'h0000_0100, 8'hE4, 1'b0, 1'b0},
    '{1'b1, 32'h00C0_1000, 8'h1B, 1'b1, 1'b1},
    '{1'b1, 32'h03C0_1000, 8'h1B, 1'b1, 1'b1},
    '{1'b1, 32'hFFFF_FFFF, 8'hAA, 1'b0, 1'b0},
    '{1'b1, 32'h0230_0004, 8'h55, 1'b1, 1'b0}
  };

  // independent restatement: geometry by code, masks by arithmetic
  task automatic model(input logic [31:0] a, input logic [7:0] c,
                       output int bank, output int row, output int col);
    int code, rb, cb;
    bank = int'(a[25:24]);
    code = (int'(c) >> (2 * bank)) % 4;   // R2 field of bank n at [2n+1:2n]
    case (code)
      0: begin rb = 9;  cb = 9;  end     // R3
      1: begin rb = 10; cb = 10; end     // R4
      2: begin rb = 11; cb = 11; end     // R5
      default: begin rb = 11; cb = 10; end // R6
    endcase
    row = int'(a >> 13) % (1 << rb);     // R7, R8
    col = int'(a >> 2) % (1 << cb);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [31:0] a, input logic [7:0] c,
                       input logic eh, input logic ea);
    int eb, er, ec;
    @(negedge clk);
    req_valid = v; req_addr = a; bank_cfg = c;
    @(negedge clk);  // one posedge in between: registered result visible
    model(a, c, eb, er, ec);
    chk("R1 bank", int'(map_bank), eb);
    chk("R10 hit", int'(map_hit), int'(eh));
    chk("R7 row", int'(map_row), er);
    chk("R7 col", int'(map_col), ec);
    chk("R9 alias", int'(map_alias), int'(ea));
  endtask

  initial begin
    // R11: reset state with busy inputs
    req_valid = 1'b1; req_addr = 32'h00F0_3FFC; bank_cfg = 8'h00;
    repeat (3) @(negedge clk);
    chk("R11 reset hit", int'(map_hit), 0);
    chk("R11 reset row", int'(map_row), 0);
    chk("R11 reset col", int'(map_col), 0);
    chk("R11 reset alias", int'(map_alias), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      apply(VECS[i].v, VECS[i].a, VECS[i].c, VECS[i].hit, VECS[i].al);

    // R10: edge of 64 MB
    apply(1'b1, 32'h03FF_FFFC, 8'hAA, 1'b1, 1'b0);
    // R10: strobe low still maps address
    apply(1'b0, 32'h0090_0000, 8'h00, 1'b0, 1'b1);
    // R3/R8: all ones in bank 0 of 1 MB code -> widths capped at 9
    apply(1'b1, 32'h00FF_FFFF, 8'h00, 1'b1, 1'b1);
    // R6: 8 MB code, highest in-capacity address
    apply(1'b1, 32'h007F_FFFC, 8'hFF, 1'b1, 1'b0);

    // R11: reset in the middle of traffic clears at once
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h02F0_0004; bank_cfg = 8'h00;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 midrun hit", int'(map_hit), 0);
    chk("R11 midrun alias", int'(map_alias), 0);
    chk("R11 midrun bank", int'(map_bank), 0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(1'b1, 32'h0240_2008, 8'h10, 1'b1, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule